// File: doc/BRIEF.md
# Storage Command Sequencer

This block sits between user logic and the command engine of a storage host controller. User logic presents a request made of a 3-bit opcode, a 48-bit start sector and a 48-bit sector count, and waits for a busy flag. The block checks the request against the drive capacity and the sector mode learned at identification. It rejects bad requests with a one-cycle error pulse. Good requests go to a downstream command port, one sub-command at a time.

Write and read transfers longer than 256 sectors (128 KB) are cut into sub-commands of at most 256 sectors at rising start sectors. The last sub-command carries the remainder. A write sub-command waits until enough write data is buffered. A read sub-command waits until the data buffer has enough free room. After the last read completes, the block stays busy until the buffer reports empty. Identify, Shutdown, SMART and Flush each issue a single sub-command that carries no sectors. After Shutdown, or after an initialization error, the block becomes inactive and ignores all requests until reset.

Top module: `storage_cmd_seq`

## Requirements
- R1: `busy` is 1 from reset until both `init_done` and `link_up` are 1. If `init_err` is 1 while initializing, the block goes inactive instead.
- R2: A request taken while `busy` and `inactive` are 0 sets `busy` on the next cycle. `busy` returns to 0 after the final sub-command's `sub_done`. Requests made while busy have no effect.
- R3: Opcodes are 000 Identify, 001 Shutdown, 010 Write, 011 Read, 100 SMART and 110 Flush. Opcodes 101 and 111 are rejected.
- R4: A Write or Read is rejected when its length is zero or when start plus length exceeds `cap_sectors`. Start plus length equal to `cap_sectors` is accepted. A rejection gives a one-cycle `param_err` pulse on the cycle after the request, and `busy` stays 0.
- R5: When `mode_4k` is 1, a Write or Read whose start or length has any of bits [2:0] set is rejected as in R4.
- R6: A Write or Read is issued as sub-commands of min(remaining, 256) sectors. The first starts at the request start sector, and each later one starts where the previous one ended.
- R7: A write sub-command is issued only while `wr_avail` (buffered sectors) is at least its sector count.
- R8: A read sub-command is issued only while `rd_free` (free sectors) is at least its sector count. After the last read completes, `busy` stays 1 until `rd_empty` is 1.
- R9: `sub_valid` and its fields stay stable until `sub_ready`. The next sub-command is not presented before `sub_done` for the current one.
- R10: Identify, Shutdown, SMART and Flush issue exactly one sub-command, with the request opcode, start 0 and count 0.
- R11: After Shutdown completes, `inactive` is 1 and requests raise neither `busy`, `param_err` nor `sub_valid` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Controller initialization finished |
| init_err | input | 1 | Controller initialization failed |
| link_up | input | 1 | Link is up |
| req | input | 1 | Command request |
| req_op | input | 3 | Opcode |
| req_addr | input | 48 | Start sector |
| req_len | input | 48 | Sector count |
| busy | output | 1 | Block busy |
| param_err | output | 1 | One-cycle pulse when a request is rejected |
| inactive | output | 1 | Block inactive until reset |
| cap_sectors | input | 48 | Drive capacity in sectors |
| mode_4k | input | 1 | 1 when the drive uses 4 KB logical blocks |
| wr_avail | input | 16 | Buffered write data, in sectors |
| rd_free | input | 16 | Free read-buffer room, in sectors |
| rd_empty | input | 1 | Read buffer fully drained to the user |
| sub_valid | output | 1 | Sub-command valid |
| sub_ready | input | 1 | Downstream accepts sub-command |
| sub_op | output | 3 | Sub-command opcode |
| sub_addr | output | 48 | Sub-command start sector |
| sub_cnt | output | 9 | Sub-command sector count |
| sub_done | input | 1 | One-cycle completion pulse |

## Verification
Every output comes from a register that is loaded at the edge after its cause. A request placed on the falling edge therefore shows `busy` or `param_err` on the next falling edge, and `param_err` has cleared one falling edge later. The bench drives inputs and samples outputs only on falling edges, so each check lands exactly one cycle after its stimulus.

The scoreboard compares each sub-command at the falling edge where `sub_valid` and `sub_ready` are both high. The responder answers with `sub_done` three cycles after that handshake. Gating and drain checks hold the buffer inputs low for a fixed window and look for a quiet port or a held `busy` throughout it.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        OP_IDENT = 3'b000,
        OP_SHUT  = 3'b001,
        OP_WRITE = 3'b010,
        OP_READ  = 3'b011,
        OP_SMART = 3'b100,
        OP_RSV5  = 3'b101,
        OP_FLUSH = 3'b110,
        OP_RSV7  = 3'b111
    } op_e;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_GATE,
        ST_ISSUE,
        ST_WAIT,
        ST_DRAIN,
        ST_DEAD
    } state_e;
endpackage

// File: rtl/seq_cmd_check.sv
module seq_cmd_check #(
    parameter int ADDR_W = 48
) (
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] len,
    input  logic [ADDR_W-1:0] cap,
    input  logic              mode_4k,
    output logic              ok,
    output logic              is_rw
);
    import seq_pkg::*;

    logic [ADDR_W:0] end_sect;
    logic            reserved;
    logic            bad_range;
    logic            misaligned;

    always_comb begin
        is_rw      = (op == OP_WRITE) || (op == OP_READ);
        reserved   = (op == OP_RSV5) || (op == OP_RSV7);
        end_sect   = {1'b0, addr} + {1'b0, len};
        bad_range  = (len == '0) || (end_sect > {1'b0, cap});
        misaligned = mode_4k && ((addr[2:0] != 3'b000) || (len[2:0] != 3'b000));
        ok         = !reserved && (!is_rw || (!bad_range && !misaligned));
    end
endmodule

// File: rtl/seq_chunk.sv
module seq_chunk #(
    parameter int ADDR_W   = 48,
    parameter int MAX_SECT = 256,
    parameter int CNT_W    = $clog2(MAX_SECT + 1)
) (
    input  logic [ADDR_W-1:0] remain,
    output logic [CNT_W-1:0]  chunk
);
    always_comb begin
        if (remain >= ADDR_W'(MAX_SECT)) chunk = CNT_W'(MAX_SECT);
        else                             chunk = remain[CNT_W-1:0];
    end
endmodule

// File: rtl/storage_cmd_seq.sv
module storage_cmd_seq #(
    parameter int ADDR_W   = 48,
    parameter int MAX_SECT = 256,
    parameter int BUF_W    = 16,
    localparam int CNT_W   = $clog2(MAX_SECT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              init_err,
    input  logic              link_up,
    input  logic              req,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_len,
    output logic              busy,
    output logic              param_err,
    output logic              inactive,
    input  logic [ADDR_W-1:0] cap_sectors,
    input  logic              mode_4k,
    input  logic [BUF_W-1:0]  wr_avail,
    input  logic [BUF_W-1:0]  rd_free,
    input  logic              rd_empty,
    output logic              sub_valid,
    input  logic              sub_ready,
    output logic [2:0]        sub_op,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [CNT_W-1:0]  sub_cnt,
    input  logic              sub_done
);
    import seq_pkg::*;

    localparam int CMP_W = (BUF_W > CNT_W) ? BUF_W : CNT_W;

    typedef struct packed {
        state_e            st;
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] rem;
        logic              vld;
        logic [ADDR_W-1:0] s_addr;
        logic [CNT_W-1:0]  s_cnt;
        logic              err;
    } seq_t;

    seq_t r_q, r_d;

    logic             req_ok;
    logic             req_rw;
    logic [CNT_W-1:0] chunk;
    logic             room_ok;
    logic [ADDR_W-1:0] rem_next;

    seq_cmd_check #(.ADDR_W(ADDR_W)) u_check (
        .op      (req_op),
        .addr    (req_addr),
        .len     (req_len),
        .cap     (cap_sectors),
        .mode_4k (mode_4k),
        .ok      (req_ok),
        .is_rw   (req_rw)
    );

    seq_chunk #(.ADDR_W(ADDR_W), .MAX_SECT(MAX_SECT), .CNT_W(CNT_W)) u_chunk (
        .remain (r_q.rem),
        .chunk  (chunk)
    );

    always_comb begin
        if (r_q.op == OP_WRITE) room_ok = CMP_W'(wr_avail) >= CMP_W'(chunk);
        else                    room_ok = CMP_W'(rd_free) >= CMP_W'(chunk);
        rem_next = r_q.rem - ADDR_W'(r_q.s_cnt);
    end

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        unique case (r_q.st)
            ST_INIT: begin
                if (init_err)                  r_d.st = ST_DEAD;
                else if (init_done && link_up) r_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req) begin
                    if (!req_ok) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.op = req_op;
                        if (req_rw) begin
                            r_d.addr = req_addr;
                            r_d.rem  = req_len;
                            r_d.st   = ST_GATE;
                        end else begin
                            r_d.addr   = '0;
                            r_d.rem    = '0;
                            r_d.vld    = 1'b1;
                            r_d.s_addr = '0;
                            r_d.s_cnt  = '0;
                            r_d.st     = ST_ISSUE;
                        end
                    end
                end
            end
            ST_GATE: begin
                if (room_ok) begin
                    r_d.vld    = 1'b1;
                    r_d.s_addr = r_q.addr;
                    r_d.s_cnt  = chunk;
                    r_d.st     = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (sub_ready) begin
                    r_d.vld = 1'b0;
                    r_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (sub_done) begin
                    if (r_q.op == OP_WRITE || r_q.op == OP_READ) begin
                        r_d.rem  = rem_next;
                        r_d.addr = r_q.addr + ADDR_W'(r_q.s_cnt);
                        if (rem_next != '0)          r_d.st = ST_GATE;
                        else if (r_q.op == OP_READ)  r_d.st = ST_DRAIN;
                        else                         r_d.st = ST_IDLE;
                    end else if (r_q.op == OP_SHUT) begin
                        r_d.st = ST_DEAD;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_DRAIN: begin
                if (rd_empty) r_d.st = ST_IDLE;
            end
            ST_DEAD: begin
                r_d.st = ST_DEAD;
            end
            default: r_d.st = ST_DEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_INIT;
            r_q.op     <= '0;
            r_q.addr   <= '0;
            r_q.rem    <= '0;
            r_q.vld    <= 1'b0;
            r_q.s_addr <= '0;
            r_q.s_cnt  <= '0;
            r_q.err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE) && (r_q.st != ST_DEAD);
    assign inactive  = (r_q.st == ST_DEAD);
    assign param_err = r_q.err;
    assign sub_valid = r_q.vld;
    assign sub_op    = r_q.op;
    assign sub_addr  = r_q.s_addr;
    assign sub_cnt   = r_q.s_cnt;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int ADDR_W   = 48,
    parameter int MAX_SECT = 256,
    parameter int CNT_W    = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              param_err,
    input logic              inactive,
    input logic              sub_valid,
    input logic              sub_ready,
    input logic [2:0]        sub_op,
    input logic [ADDR_W-1:0] sub_addr,
    input logic [CNT_W-1:0]  sub_cnt
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr) && $stable(sub_cnt) && $stable(sub_op)));

    assert_valid_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> busy);

    assert_chunk_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (32'(sub_cnt) <= 32'(MAX_SECT)));

    assert_reject_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        param_err |-> !busy);

    assert_dead_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inactive |=> (inactive && !busy && !param_err && !sub_valid));

    assert_no_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (sub_op != 3'b101 && sub_op != 3'b111));
endmodule

bind storage_cmd_seq seq_checker #(
    .ADDR_W(ADDR_W), .MAX_SECT(MAX_SECT), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .param_err (param_err),
    .inactive  (inactive),
    .sub_valid (sub_valid),
    .sub_ready (sub_ready),
    .sub_op    (sub_op),
    .sub_addr  (sub_addr),
    .sub_cnt   (sub_cnt)
);

// File: tb/sim_storage_cmd_seq.sv
module sim_storage_cmd_seq;
    localparam int AW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_done = 1'b0, init_err = 1'b0, link_up = 1'b0;
    logic          req = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0, req_len = '0;
    logic          busy, param_err, inactive;
    logic [AW-1:0] cap_sectors = 48'd10000;
    logic          mode_4k = 1'b0;
    logic [15:0]   wr_avail = 16'd0, rd_free = 16'd0;
    logic          rd_empty = 1'b1;
    logic          sub_valid, sub_ready;
    logic [2:0]    sub_op;
    logic [AW-1:0] sub_addr;
    logic [8:0]    sub_cnt;
    logic          sub_done = 1'b0;
    logic          rdy_en = 1'b1;

    assign sub_ready = rdy_en;

    always #10 clk = ~clk;

    storage_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .init_err(init_err),
        .link_up(link_up), .req(req), .req_op(req_op), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .param_err(param_err), .inactive(inactive),
        .cap_sectors(cap_sectors), .mode_4k(mode_4k), .wr_avail(wr_avail),
        .rd_free(rd_free), .rd_empty(rd_empty), .sub_valid(sub_valid),
        .sub_ready(sub_ready), .sub_op(sub_op), .sub_addr(sub_addr),
        .sub_cnt(sub_cnt), .sub_done(sub_done)
    );

    int n_chk = 0;
    int n_err = 0;

    typedef struct { logic [2:0] op; logic [AW-1:0] addr; logic [8:0] cnt; } sub_t;
    sub_t exp_q[$];

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Monitor and responder: compare handshakes with the queue, answer with done.
    int done_ctr = 0;
    always @(negedge clk) begin
        sub_done = 1'b0;
        if (done_ctr > 0) begin
            done_ctr--;
            if (done_ctr == 0) sub_done = 1'b1;
        end
        if (rst_n && sub_valid && sub_ready) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected sub-command", {13'd0, sub_op, sub_addr}, 64'hFFFF);
            end else begin
                sub_t e;
                e = exp_q.pop_front();
                chk("R6 sub op", 64'(sub_op), 64'(e.op));
                chk("R6 sub addr", 64'(sub_addr), 64'(e.addr));
                chk("R6 sub cnt", 64'(sub_cnt), 64'(e.cnt));
            end
            done_ctr = 3;
        end
    end

    // Driver: push expected sub-commands, then place the request for one cycle.
    task automatic issue(logic [2:0] op, logic [AW-1:0] a, logic [AW-1:0] l, bit bad, string rq);
        if (!bad) begin
            if (op == 3'b010 || op == 3'b011) begin
                logic [AW-1:0] rem = l;
                logic [AW-1:0] p = a;
                while (rem != 0) begin
                    sub_t s;
                    s.op = op; s.addr = p;
                    s.cnt = (rem >= 256) ? 9'd256 : rem[8:0];
                    exp_q.push_back(s);
                    p = p + AW'(s.cnt);
                    rem = rem - AW'(s.cnt);
                end
            end else begin
                sub_t s;
                s.op = op; s.addr = '0; s.cnt = '0;
                exp_q.push_back(s);
            end
        end
        @(negedge clk);
        req_op = op; req_addr = a; req_len = l; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk({rq, " param_err"}, 64'(param_err), 64'(bad));
        chk({rq, " busy"}, 64'(busy), 64'(!bad));
        if (bad) begin
            @(negedge clk);
            chk({rq, " pulse one cycle"}, 64'(param_err), 64'd0);
        end
    endtask

    task automatic wait_idle(string rq);
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({rq, " returns idle"}, 64'(busy), 64'd0);
        chk({rq, " queue drained"}, 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 64'(busy), 64'd1);
        chk("R1 no sub after reset", 64'(sub_valid), 64'd0);
        init_done = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy without link", 64'(busy), 64'd1);
        link_up = 1'b1;
        @(negedge clk);
        chk("R1 idle after init and link", 64'(busy), 64'd0);

        // R10 Identify, with a downstream stall to exercise R9
        rdy_en = 1'b0;
        issue(3'b000, 48'd77, 48'd5, 1'b0, "R10 identify");
        repeat (5) @(negedge clk);
        chk("R9 valid held during stall", 64'(sub_valid), 64'd1);
        rdy_en = 1'b1;
        wait_idle("R10 identify");

        // R3 reserved opcodes and R4 parameter errors
        issue(3'b101, 48'd0, 48'd8, 1'b1, "R3 reserved 101");
        issue(3'b111, 48'd0, 48'd8, 1'b1, "R3 reserved 111");
        issue(3'b010, 48'd0, 48'd0, 1'b1, "R4 zero length");
        issue(3'b011, 48'd9700, 48'd301, 1'b1, "R4 beyond capacity");
        chk("R4 no sub after rejects", 64'(exp_q.size()), 64'd0);

        // R7 write gating, R6 chunking
        wr_avail = 16'd0;
        issue(3'b010, 48'd1000, 48'd300, 1'b0, "R7 write");
        begin
            int seen = 0;
            repeat (20) begin
                @(negedge clk);
                if (sub_valid) seen++;
            end
            chk("R7 write waits for data", 64'(seen), 64'd0);
        end
        wr_avail = 16'd256;
        wait_idle("R6 write 300");

        // R4 boundary: end exactly at capacity
        issue(3'b010, 48'd9700, 48'd300, 1'b0, "R4 at capacity");
        wait_idle("R4 at capacity");

        // R2 request during busy is ignored
        wr_avail = 16'd0;
        issue(3'b010, 48'd0, 48'd8, 1'b0, "R2 write");
        @(negedge clk);
        req_op = 3'b100; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wr_avail = 16'd8;
        wait_idle("R2 busy ignores request");

        // R8 read gating, chunking and drain
        rd_free = 16'd100;
        rd_empty = 1'b0;
        issue(3'b011, 48'd0, 48'd600, 1'b0, "R8 read");
        begin
            int seen = 0;
            repeat (20) begin
                @(negedge clk);
                if (sub_valid) seen++;
            end
            chk("R8 read waits for room", 64'(seen), 64'd0);
        end
        rd_free = 16'd256;
        begin
            int n = 0;
            while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
        end
        repeat (15) @(negedge clk);
        chk("R8 busy until drained", 64'(busy), 64'd1);
        rd_empty = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wait_idle("R8 read drain");

        // R5 alignment in 4 KB mode
        mode_4k = 1'b1;
        issue(3'b011, 48'd8, 48'd12, 1'b1, "R5 misaligned length");
        issue(3'b010, 48'd3, 48'd16, 1'b1, "R5 misaligned start");
        issue(3'b011, 48'd16, 48'd16, 1'b0, "R5 aligned read");
        wait_idle("R5 aligned read");
        mode_4k = 1'b0;

        // R10 SMART and Flush
        issue(3'b100, 48'd5, 48'd5, 1'b0, "R10 smart");
        wait_idle("R10 smart");
        issue(3'b110, 48'd0, 48'd0, 1'b0, "R10 flush");
        wait_idle("R10 flush");

        // R11 shutdown then locked out
        issue(3'b001, 48'd0, 48'd0, 1'b0, "R11 shutdown");
        wait_idle("R11 shutdown");
        chk("R11 inactive", 64'(inactive), 64'd1);
        @(negedge clk);
        req_op = 3'b010; req_addr = 48'd0; req_len = 48'd8; req = 1'b1;
        @(negedge clk);
        chk("R11 no busy", 64'(busy), 64'd0);
        chk("R11 no param_err", 64'(param_err), 64'd0);
        req_op = 3'b111;
        @(negedge clk);
        req = 1'b0;
        chk("R11 reserved op ignored", 64'(param_err), 64'd0);
        repeat (5) @(negedge clk);
        chk("R11 no sub", 64'(sub_valid), 64'd0);

        // R1 initialization error path
        rst_n = 1'b0;
        init_done = 1'b0;
        init_err = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 init error inactive", 64'(inactive), 64'd1);
        init_done = 1'b1;
        init_err = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 stays inactive", 64'(inactive), 64'd1);
        chk("R1 not busy when inactive", 64'(busy), 64'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule